// File: doc/BRIEF.md
# Return-Address Encryption Unit

This unit sits beside a processor's call/return path and keeps return addresses on the software stack unreadable and unforgeable by a buffer overflow. When a call is executed, the 32-bit return address is handed to the unit, which encrypts it with a secret key of the running process; only the resulting 32-bit word is written to the stack. When a return is executed, the word read back from the stack is handed to the unit, which decrypts it with the same key and presents the original address as the jump target. An overwritten stack slot therefore decrypts to a meaningless target.

The cipher is a 16-round balanced Feistel network on two 16-bit halves, one round per clock. The round function adds a 16-bit subkey to the right half, rotates the sum left by 5 and XORs the subkey in; the left half is XORed with that value and the halves swap. The subkey of round i (0..15) is the low 16 bits of the 64-bit process key rotated left by 4*i. Decryption swaps the halves in, runs the rounds with the subkeys in reverse order, and swaps them out. Keys live in an 8-entry table indexed by a 3-bit process number; the table has no output port. Registering a process copies the current value of a free-running 64-bit LFSR into its entry.

Top module: `ret_addr_cipher`

## Requirements
- R1: With req_ret=0 the result is the encryption of req_word: L/R start as bits [31:16]/[15:0], each round sets (L,R) to (R, L ^ (rotl5(R+k) ^ k)), the result is {L,R} after 16 rounds, and round i uses bits [15:0] of the key rotated left by 4*i.
- R2: With req_ret=1 and the same process number, the result is exactly the address whose encryption was supplied.
- R3: done is high for exactly one cycle, 16 rising edges after the edge that accepts a request; busy is high from that edge until done rises and is low while done is high.
- R4: req_ack is high only while busy is low; a request presented while busy is not accepted, starts no operation and does not change the result of the one in progress.
- R5: Processes registered separately hold separate keys, so one address encrypts to different words under different registered process numbers.
- R6: A pulse on new_proc loads the entry new_pid from the LFSR, which never holds zero; afterwards that process no longer encrypts like a zero key, and re-registering changes its ciphertext so old ciphertext no longer decrypts to the original address.
- R7: The key used by an operation is captured when it is accepted; registering the same process while the operation runs does not change its result.
- R8: After reset busy, done and result_word are 0 and every key entry is zero, so an unregistered process encrypts with the all-zero key.
- R9: Encrypting the same address under the same unchanged key always gives the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| new_proc | input | 1 | One-cycle pulse: generate a key for new_pid |
| new_pid | input | 3 | Process number whose key entry is refreshed |
| cur_pid | input | 3 | Process number of the running request |
| req_valid | input | 1 | Request present |
| req_ret | input | 1 | 0 = call (encrypt), 1 = return (decrypt) |
| req_word | input | 32 | Return address or popped stack word |
| req_ack | output | 1 | Request accepted this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse, result_word valid |
| result_word | output | 32 | Encrypted word or recovered address |

## Verification
Keys come from an LFSR that cannot be read, so exact ciphertext is only predictable for unregistered processes, whose key is zero; the bench uses those for bit-exact checks of the round structure and uses round trips and inequality for registered ones. The hardest case is a key refresh of the same process landing in the middle of its own operation: the bench starts an encryption under a known-zero key and pulses the registration a few rounds later, then compares the result against the zero-key model. Requests arriving while busy are forced the same way, by holding req_valid with a different word during the rounds.

// File: rtl/rac_pkg.sv
package rac_pkg;
    localparam int WORD_W    = 32;
    localparam int HALF_W    = WORD_W / 2;
    localparam int KEY_W     = 64;
    localparam int ROUNDS    = 16;
    localparam int CNT_W     = $clog2(ROUNDS);
    localparam int PROC_N    = 8;
    localparam int PID_W     = $clog2(PROC_N);
    localparam int MIX_ROT   = 5;
    localparam int KEY_STEP  = 4;
    localparam int SH_W      = $clog2(KEY_W) + 1;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic              dec;
        logic [CNT_W-1:0]  cnt;
        logic [HALF_W-1:0] lh;
        logic [HALF_W-1:0] rh;
        logic [KEY_W-1:0]  key;
        logic [WORD_W-1:0] result;
    } core_st_t;
endpackage

// File: rtl/rac_lfsr.sv
module rac_lfsr #(
    parameter int          W    = 64,
    parameter logic [63:0] TAPS = 64'hD800_0000_0000_0000,
    parameter logic [63:0] SEED = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    logic [W-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[W-2:0], ^(st_q & TAPS[W-1:0])};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= SEED[W-1:0];
        else        st_q <= st_d;
    end

    assign state = st_q;
endmodule

// File: rtl/rac_key_table.sv
module rac_key_table
    import rac_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [PID_W-1:0] wr_pid,
    input  logic [KEY_W-1:0] wr_key,
    input  logic [PID_W-1:0] rd_pid,
    output logic [KEY_W-1:0] rd_key
);
    logic [KEY_W-1:0] ent_q [PROC_N];

    for (genvar g = 0; g < PROC_N; g++) begin : g_ent
        logic [KEY_W-1:0] ent_d;
        always_comb begin
            ent_d = ent_q[g];
            if (wr_en && (wr_pid == PID_W'(g))) ent_d = wr_key;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[g] <= '0;
            else        ent_q[g] <= ent_d;
        end
    end

    assign rd_key = ent_q[rd_pid];
endmodule

// File: rtl/rac_round.sv
module rac_round
    import rac_pkg::*;
(
    input  logic [KEY_W-1:0]  key,
    input  logic [CNT_W-1:0]  idx,
    input  logic [HALF_W-1:0] half_in,
    output logic [HALF_W-1:0] mix_out
);
    logic [2*KEY_W-1:0] dbl;
    logic [SH_W-1:0]    sh;
    logic [SH_W-1:0]    base;
    logic [HALF_W-1:0]  sub;
    logic [HALF_W-1:0]  sum;

    always_comb begin
        dbl     = {key, key};
        sh      = SH_W'(idx) * SH_W'(KEY_STEP);
        base    = SH_W'(KEY_W) - sh;
        sub     = dbl[base +: HALF_W];
        sum     = half_in + sub;
        mix_out = {sum[HALF_W-MIX_ROT-1:0], sum[HALF_W-1:HALF_W-MIX_ROT]} ^ sub;
    end
endmodule

// File: rtl/ret_addr_cipher.sv
module ret_addr_cipher
    import rac_pkg::*;
#(
    parameter logic [63:0] LFSR_SEED = 64'h9E37_79B9_7F4A_7C15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              new_proc,
    input  logic [PID_W-1:0]  new_pid,
    input  logic [PID_W-1:0]  cur_pid,
    input  logic              req_valid,
    input  logic              req_ret,
    input  logic [WORD_W-1:0] req_word,
    output logic              req_ack,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] result_word
);
    core_st_t          st_d, st_q;
    logic [KEY_W-1:0]  lfsr_state;
    logic [KEY_W-1:0]  sel_key;
    logic [CNT_W-1:0]  rnd_idx;
    logic [HALF_W-1:0] mix;
    logic [HALF_W-1:0] nl, nr;

    rac_lfsr #(.W(KEY_W), .SEED(LFSR_SEED)) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_state)
    );

    rac_key_table u_keys (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (new_proc),
        .wr_pid (new_pid),
        .wr_key (lfsr_state),
        .rd_pid (cur_pid),
        .rd_key (sel_key)
    );

    assign rnd_idx = st_q.dec ? CNT_W'(ROUNDS - 1) - st_q.cnt : st_q.cnt;

    rac_round u_round (
        .key     (st_q.key),
        .idx     (rnd_idx),
        .half_in (st_q.rh),
        .mix_out (mix)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        nl        = st_q.rh;
        nr        = st_q.lh ^ mix;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy = 1'b1;
                st_d.dec  = req_ret;
                st_d.cnt  = '0;
                st_d.key  = sel_key;
                if (req_ret) begin
                    st_d.lh = req_word[HALF_W-1:0];
                    st_d.rh = req_word[WORD_W-1:HALF_W];
                end else begin
                    st_d.lh = req_word[WORD_W-1:HALF_W];
                    st_d.rh = req_word[HALF_W-1:0];
                end
            end
        end else begin
            st_d.lh  = nl;
            st_d.rh  = nr;
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CNT_W'(ROUNDS - 1)) begin
                st_d.busy   = 1'b0;
                st_d.done   = 1'b1;
                st_d.result = st_q.dec ? {nr, nl} : {nl, nr};
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ack     = req_valid && !st_q.busy;
    assign busy        = st_q.busy;
    assign done        = st_q.done;
    assign result_word = st_q.result;
endmodule

// File: rtl/rac_checker.sv
module rac_checker #(
    parameter int ROUNDS = 16,
    parameter int KEY_W  = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ack,
    input logic             busy,
    input logic             done,
    input logic [KEY_W-1:0] lfsr_state
);
    localparam int LAT_W = $clog2(ROUNDS + 2) + 1;
    logic [LAT_W-1:0] lat_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  lat_q <= '0;
        else if (req_valid && req_ack) lat_q <= LAT_W'(1);
        else if (busy)               lat_q <= lat_q + 1'b1;
    end

    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> lat_q == LAT_W'(ROUNDS + 1)); // R3
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R3
    AST_BUSY_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done)); // R3
    AST_IDLE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R3
    AST_START_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(req_valid && req_ack)); // R4
    AST_LFSR_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        lfsr_state != '0); // R6
endmodule

bind ret_addr_cipher rac_checker #(.ROUNDS(rac_pkg::ROUNDS), .KEY_W(rac_pkg::KEY_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ack    (req_ack),
    .busy       (busy),
    .done       (done),
    .lfsr_state (lfsr_state)
);

// File: tb/sim_ret_addr_cipher.sv
module sim_ret_addr_cipher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        new_proc = 1'b0;
    logic [2:0]  new_pid = '0;
    logic [2:0]  cur_pid = '0;
    logic        req_valid = 1'b0;
    logic        req_ret = 1'b0;
    logic [31:0] req_word = '0;
    logic        req_ack, busy, done;
    logic [31:0] result_word;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #5ns clk = ~clk;

    ret_addr_cipher u0 (
        .clk(clk), .rst_n(rst_n), .new_proc(new_proc), .new_pid(new_pid),
        .cur_pid(cur_pid), .req_valid(req_valid), .req_ret(req_ret),
        .req_word(req_word), .req_ack(req_ack), .busy(busy), .done(done),
        .result_word(result_word)
    );

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: run hung, act=%0d cycles exp<=100000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%08h exp=%08h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] model_enc(input logic [31:0] x, input logic [63:0] k);
        logic [15:0] l = x[31:16];
        logic [15:0] r = x[15:0];
        for (int i = 0; i < 16; i++) begin
            logic [63:0] rk = (i == 0) ? k : ((k << (4 * i)) | (k >> (64 - 4 * i)));
            logic [15:0] sk = rk[15:0];
            logic [15:0] s  = r + sk;
            logic [15:0] f  = {s[10:0], s[15:11]} ^ sk;
            logic [15:0] t  = l ^ f;
            l = r;
            r = t;
        end
        return {l, r};
    endfunction

    task automatic start_op(input bit ret, input logic [2:0] pid, input logic [31:0] w);
        @(negedge clk);
        cur_pid = pid; req_ret = ret; req_word = w; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(output logic [31:0] res, output int lat);
        lat = 0;
        while (!done && lat < 40) begin
            @(posedge clk);
            @(negedge clk);
            lat++;
        end
        res = result_word;
    endtask

    task automatic run_op(input bit ret, input logic [2:0] pid, input logic [31:0] w,
                          output logic [31:0] res, output int lat);
        start_op(ret, pid, w);
        wait_done(res, lat);
    endtask

    task automatic reg_proc(input logic [2:0] pid);
        @(negedge clk);
        new_pid = pid; new_proc = 1'b1;
        @(negedge clk);
        new_proc = 1'b0;
    endtask

    initial begin
        logic [31:0] c, p, c2, c3, x;
        logic [31:0] cv [6];
        int lat;
        void'($urandom(32'd4242));

        repeat (3) @(negedge clk);
        // R8: reset state
        chk(busy == 1'b0, "R8 busy after reset", 32'(busy), 0);
        chk(done == 1'b0, "R8 done after reset", 32'(done), 0);
        chk(result_word == 32'h0, "R8 result after reset", result_word, 0);
        rst_n = 1'b1;
        @(negedge clk);
        req_valid = 1'b1;
        #1;
        chk(req_ack == 1'b1, "R4 ack while idle", 32'(req_ack), 1);
        req_valid = 1'b0;

        // R1/R8: bit-exact encryption with the zero key of unregistered pid 7
        foreach (cv[i]) begin
            x = (i == 0) ? 32'h0 : (i == 1) ? 32'hFFFF_FFFF : $urandom;
            run_op(1'b0, 3'd7, x, c, lat);
            chk(c == model_enc(x, 64'h0), "R1 zero-key ciphertext", c, model_enc(x, 64'h0));
            chk(lat == 16, "R3 latency encrypt", 32'(lat), 16);
            @(negedge clk);
            chk(done == 1'b0, "R3 done one cycle", 32'(done), 0);
            run_op(1'b1, 3'd7, c, p, lat);
            chk(p == x, "R2 zero-key round trip", p, x);
            chk(lat == 16, "R3 latency decrypt", 32'(lat), 16);
        end

        // register processes 0..5
        for (int i = 0; i < 6; i++) begin
            reg_proc(3'(i));
            repeat ($urandom_range(1, 7)) @(negedge clk);
        end

        // R2/R6/R9: random round trips under registered keys
        for (int n = 0; n < 24; n++) begin
            logic [2:0] pid = 3'($urandom_range(0, 5));
            x = $urandom;
            run_op(1'b0, pid, x, c, lat);
            chk(c != model_enc(x, 64'h0), "R6 registered key is not zero", c, model_enc(x, 64'h0));
            run_op(1'b0, pid, x, c2, lat);
            chk(c2 == c, "R9 repeat encryption", c2, c);
            run_op(1'b1, pid, c, p, lat);
            chk(p == x, "R2 round trip", p, x);
        end

        // R5: same address under six processes gives six ciphertexts
        x = 32'h0040_1234;
        for (int i = 0; i < 6; i++) run_op(1'b0, 3'(i), x, cv[i], lat);
        for (int i = 0; i < 6; i++)
            for (int j = i + 1; j < 6; j++)
                chk(cv[i] != cv[j], "R5 distinct per-process ciphertext", cv[i], cv[j]);

        // R4: requests while busy are refused and leave the result intact
        x = 32'h8000_0F00;
        start_op(1'b0, 3'd7, x);
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            req_valid = 1'b1; req_ret = 1'b1; req_word = 32'hDEAD_BEEF; cur_pid = 3'd0;
            #1;
            chk(req_ack == 1'b0, "R4 no ack while busy", 32'(req_ack), 0);
        end
        @(negedge clk);
        req_valid = 1'b0;
        wait_done(c, lat);
        chk(c == model_enc(x, 64'h0), "R4 result untouched by refused request", c, model_enc(x, 64'h0));
        repeat (20) @(negedge clk);
        chk(!busy && !done, "R4 refused request started nothing", {30'b0, busy, done}, 0);

        // R7: re-keying the same process mid-operation
        x = 32'h1234_5678;
        start_op(1'b0, 3'd6, x);
        repeat (3) @(negedge clk);
        new_pid = 3'd6; new_proc = 1'b1;
        @(negedge clk);
        new_proc = 1'b0;
        wait_done(c, lat);
        chk(c == model_enc(x, 64'h0), "R7 key captured at acceptance", c, model_enc(x, 64'h0));
        run_op(1'b0, 3'd6, x, c2, lat);
        chk(c2 != model_enc(x, 64'h0), "R6 new key in use after registration", c2, model_enc(x, 64'h0));

        // R6: re-registering invalidates old ciphertext
        x = 32'h0BAD_F00D;
        run_op(1'b0, 3'd0, x, c, lat);
        reg_proc(3'd0);
        run_op(1'b0, 3'd0, x, c3, lat);
        chk(c3 != c, "R6 re-registration changes ciphertext", c3, c);
        run_op(1'b1, 3'd0, c, p, lat);
        chk(p != x, "R6 old ciphertext no longer decrypts", p, x);
        run_op(1'b1, 3'd0, c3, p, lat);
        chk(p == x, "R2 round trip after re-key", p, x);

        finish_run();
    end
endmodule